// File: doc/BRIEF.md
# Codec Command and Response Ring Engine

This block moves traffic between a host and the codecs on an audio link through two rings in system memory. On the outbound ring the host writes 32-bit command words and advances a write pointer. The engine fetches each new entry over a memory-read port and hands it to the codec command port. On the inbound ring, each codec response is stored as a two-dword entry over a memory-write port. The engine then advances its own write pointer so the host can see it.

Software sets the configuration as steady levels: ring bases, 2-bit size selects, the command write pointer, the command run bit and the response DMA enable. A response counter is compared with a programmable threshold. The counter also fires when a command batch drains. It sets a response-interrupt flag, which software clears with a one-cycle pulse.

Top module: `cmdring_engine`

## Requirements
- R1: Size select code 0 gives a 2-entry ring, code 1 a 16-entry ring and code 2 a 256-entry ring. Both pointers wrap modulo the selected size.
- R2: Size code 3 is invalid. With code 3 the command side does not start on a run rising edge, and the response side keeps `rsp_ready` low.
- R3: The command side starts only on a 0-to-1 change of `cmd_run`. A run bit that is already high when the size becomes valid starts nothing. A low run bit sets `cmd_rp` to 0 on the next cycle.
- R4: While started and while `cmd_rp` differs from `cmd_wp`, the engine forms rp+1 modulo the size. It reads the dword at `cmd_base` + 4×(rp+1), and once that dword is dispatched it publishes rp+1 on `cmd_rp`.
- R5: Bits 31:28 of a command word select the codec. If the bit for that codec in `codec_present` is 0, the command is not issued on the codec port, and the ring still advances past it.
- R6: For each accepted response, the engine forms wp+1 modulo the size. It writes the response dword at `rsp_base` + 8×(wp+1), then on the next cycle writes a second dword at +4 holding the codec address in bits 3:0 and the unsolicited flag in bit 4. After that it publishes `rsp_wp`. The response base is 8-byte aligned.
- R7: Each stored response counts once. When the count equals `irq_count` and `irq_en` is high, `irq_flag` sets and the count clears.
- R8: When a command batch drains (rp reaches wp after at least one fetch) with a nonzero count and `irq_en` high, `irq_flag` sets and the count clears.
- R9: With `irq_en` low, responses never set `irq_flag`. A pulse on `irq_clr` clears the flag.
- R10: `rsp_ready` is high only while `rsp_dma_en` is set and no entry is being written. Clearing `rsp_dma_en` returns `rsp_wp` to 0.
- R11: After reset, `cmd_rp`, `rsp_wp` and `irq_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_base | input | 32 | Command ring base address |
| cmd_size_sel | input | 2 | Command ring size code |
| cmd_wp | input | 8 | Command write pointer from software |
| cmd_run | input | 1 | Command side run bit |
| cmd_rp | output | 8 | Published command read pointer |
| mrd_req | output | 1 | Memory read request, one cycle |
| mrd_addr | output | 32 | Memory read address |
| mrd_valid | input | 1 | Read data valid |
| mrd_data | input | 32 | Read data |
| codec_present | input | 16 | One bit per codec address that is attached |
| cdc_cmd_valid | output | 1 | Command issued to a codec |
| cdc_cmd_addr | output | 4 | Target codec address |
| cdc_cmd_word | output | 32 | Command word |
| rsp_base | input | 32 | Response ring base address |
| rsp_size_sel | input | 2 | Response ring size code |
| rsp_dma_en | input | 1 | Response DMA enable |
| rsp_wp | output | 8 | Published response write pointer |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response accepted when valid is also high |
| rsp_data | input | 32 | Response dword |
| rsp_codec | input | 4 | Responding codec address |
| rsp_unsol | input | 1 | Response is unsolicited |
| mwr_valid | output | 1 | Memory write strobe |
| mwr_addr | output | 32 | Memory write address |
| mwr_data | output | 32 | Memory write data |
| irq_en | input | 1 | Response interrupt enable |
| irq_count | input | 8 | Response count threshold |
| irq_clr | input | 1 | Clear pulse for the interrupt flag |
| irq_flag | output | 1 | Response interrupt status |

## Verification
The bench uses the default 32-bit address and data widths and 16 codec addresses. It exercises all three legal ring sizes. A 2-entry ring shows both pointers wrapping after one step. A full 255-entry run on the 256-entry ring, followed by one more entry, shows the wrap at the widest pointer value. A codec mask with one absent address brings the silent drop into reach without changing the ring walk. A small interrupt threshold and a second, larger one separate the count-match trigger from the trigger on batch completion.

// File: rtl/cre_pkg.sv
package cre_pkg;
    localparam int PTR_W = 8;
    typedef logic [PTR_W-1:0] ptr_t;

    localparam logic [1:0] SZ_BAD = 2'd3;

    typedef enum logic [1:0] {C_IDLE, C_SCAN, C_REQ, C_WAIT} cstate_e;
    typedef enum logic [1:0] {R_IDLE, R_LO, R_HI} rstate_e;

    function automatic ptr_t size_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    return ptr_t'(1);
            2'd1:    return ptr_t'(15);
            default: return '1;
        endcase
    endfunction

    function automatic logic size_ok(input logic [1:0] sel);
        return sel != SZ_BAD;
    endfunction

    function automatic ptr_t ptr_inc(input ptr_t p, input ptr_t m);
        return (p + ptr_t'(1)) & m;
    endfunction
endpackage

// File: rtl/cre_cmd_fetch.sv
module cre_cmd_fetch
    import cre_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CODECS = 16,
    localparam int CA_W  = $clog2(CODECS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     base,
    input  logic [1:0]        size_sel,
    input  ptr_t              wp,
    input  logic              run,
    output ptr_t              rp,
    output logic              mrd_req,
    output logic [AW-1:0]     mrd_addr,
    input  logic              mrd_valid,
    input  logic [DW-1:0]     mrd_data,
    input  logic [CODECS-1:0] present,
    output logic              cmd_valid,
    output logic [CA_W-1:0]   cmd_addr,
    output logic [DW-1:0]     cmd_word,
    output logic              batch_done
);
    typedef struct packed {
        cstate_e st;
        logic    run_prev;
        logic    did;
        ptr_t    rp;
        ptr_t    nrp;
    } cf_t;

    cf_t q, d;
    ptr_t mask;

    always_comb begin
        mask       = size_mask(size_sel);
        d          = q;
        d.run_prev = run;
        mrd_req    = 1'b0;
        mrd_addr   = base + {{(AW-PTR_W-2){1'b0}}, q.nrp, 2'b00};
        cmd_valid  = 1'b0;
        cmd_addr   = mrd_data[DW-1 -: CA_W];
        cmd_word   = mrd_data;
        batch_done = 1'b0;
        if (!run) begin
            d.st  = C_IDLE;
            d.rp  = '0;
            d.did = 1'b0;
        end else begin
            case (q.st)
                C_IDLE: if (!q.run_prev && size_ok(size_sel)) d.st = C_SCAN;
                C_SCAN: begin
                    if (q.rp != (wp & mask)) begin
                        d.nrp = ptr_inc(q.rp, mask);
                        d.st  = C_REQ;
                    end else if (q.did) begin
                        batch_done = 1'b1;
                        d.did      = 1'b0;
                    end
                end
                C_REQ: begin
                    mrd_req = 1'b1;
                    d.st    = C_WAIT;
                end
                C_WAIT: begin
                    if (mrd_valid) begin
                        cmd_valid = present[cmd_addr];
                        d.rp      = q.nrp;
                        d.did     = 1'b1;
                        d.st      = C_SCAN;
                    end
                end
                default: d.st = C_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: C_IDLE, run_prev: 1'b0, did: 1'b0, rp: '0, nrp: '0};
        else        q <= d;
    end

    assign rp = q.rp;
endmodule

// File: rtl/cre_rsp_writer.sv
module cre_rsp_writer
    import cre_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int CA_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   base,
    input  logic [1:0]      size_sel,
    input  logic            dma_en,
    output ptr_t            wp,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [DW-1:0]   in_data,
    input  logic [CA_W-1:0] in_codec,
    input  logic            in_unsol,
    output logic            mwr_valid,
    output logic [AW-1:0]   mwr_addr,
    output logic [DW-1:0]   mwr_data,
    output logic            stored
);
    typedef struct packed {
        rstate_e         st;
        ptr_t            wp;
        ptr_t            nwp;
        logic [DW-1:0]   data;
        logic [CA_W:0]   ext;
    } rw_t;

    rw_t q, d;
    logic [AW-1:0] entry_addr;

    always_comb begin
        d          = q;
        in_ready   = 1'b0;
        mwr_valid  = 1'b0;
        entry_addr = base + {{(AW-PTR_W-3){1'b0}}, q.nwp, 3'b000};
        mwr_addr   = entry_addr;
        mwr_data   = q.data;
        stored     = 1'b0;
        if (!dma_en) begin
            d.st = R_IDLE;
            d.wp = '0;
        end else begin
            case (q.st)
                R_IDLE: begin
                    in_ready = size_ok(size_sel);
                    if (in_valid && in_ready) begin
                        d.nwp  = ptr_inc(q.wp, size_mask(size_sel));
                        d.data = in_data;
                        d.ext  = {in_unsol, in_codec};
                        d.st   = R_LO;
                    end
                end
                R_LO: begin
                    mwr_valid = 1'b1;
                    d.st      = R_HI;
                end
                R_HI: begin
                    mwr_valid = 1'b1;
                    mwr_addr  = entry_addr + AW'(4);
                    mwr_data  = {{(DW-CA_W-1){1'b0}}, q.ext};
                    d.wp      = q.nwp;
                    stored    = 1'b1;
                    d.st      = R_IDLE;
                end
                default: d.st = R_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: R_IDLE, wp: '0, nwp: '0, data: '0, ext: '0};
        else        q <= d;
    end

    assign wp = q.wp;
endmodule

// File: rtl/cre_rsp_irq.sv
module cre_rsp_irq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stored,
    input  logic             batch_done,
    input  logic             en,
    input  logic [CNT_W-1:0] threshold,
    input  logic             clr,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } ri_t;

    ri_t q, d;
    logic [CNT_W-1:0] cnt_i;
    logic             fire;

    always_comb begin
        cnt_i  = q.cnt + {{(CNT_W-1){1'b0}}, stored};
        fire   = en && (cnt_i != '0) && ((cnt_i == threshold) || batch_done);
        d.cnt  = fire ? '0 : cnt_i;
        d.flag = fire || (q.flag && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, flag: 1'b0};
        else        q <= d;
    end

    assign flag = q.flag;
endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
    import cre_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CODECS = 16,
    parameter int CNT_W  = 8,
    localparam int CA_W  = $clog2(CODECS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cmd_base,
    input  logic [1:0]        cmd_size_sel,
    input  logic [PTR_W-1:0]  cmd_wp,
    input  logic              cmd_run,
    output logic [PTR_W-1:0]  cmd_rp,
    output logic              mrd_req,
    output logic [AW-1:0]     mrd_addr,
    input  logic              mrd_valid,
    input  logic [DW-1:0]     mrd_data,
    input  logic [CODECS-1:0] codec_present,
    output logic              cdc_cmd_valid,
    output logic [CA_W-1:0]   cdc_cmd_addr,
    output logic [DW-1:0]     cdc_cmd_word,
    input  logic [AW-1:0]     rsp_base,
    input  logic [1:0]        rsp_size_sel,
    input  logic              rsp_dma_en,
    output logic [PTR_W-1:0]  rsp_wp,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DW-1:0]     rsp_data,
    input  logic [CA_W-1:0]   rsp_codec,
    input  logic              rsp_unsol,
    output logic              mwr_valid,
    output logic [AW-1:0]     mwr_addr,
    output logic [DW-1:0]     mwr_data,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  irq_count,
    input  logic              irq_clr,
    output logic              irq_flag
);
    logic batch_done;
    logic stored;

    cre_cmd_fetch #(.AW(AW), .DW(DW), .CODECS(CODECS)) u_fetch (
        .clk, .rst_n,
        .base(cmd_base), .size_sel(cmd_size_sel), .wp(cmd_wp), .run(cmd_run),
        .rp(cmd_rp), .mrd_req, .mrd_addr, .mrd_valid, .mrd_data,
        .present(codec_present), .cmd_valid(cdc_cmd_valid),
        .cmd_addr(cdc_cmd_addr), .cmd_word(cdc_cmd_word), .batch_done
    );

    cre_rsp_writer #(.AW(AW), .DW(DW), .CA_W(CA_W)) u_writer (
        .clk, .rst_n,
        .base(rsp_base), .size_sel(rsp_size_sel), .dma_en(rsp_dma_en),
        .wp(rsp_wp), .in_valid(rsp_valid), .in_ready(rsp_ready),
        .in_data(rsp_data), .in_codec(rsp_codec), .in_unsol(rsp_unsol),
        .mwr_valid, .mwr_addr, .mwr_data, .stored
    );

    cre_rsp_irq #(.CNT_W(CNT_W)) u_irq (
        .clk, .rst_n, .stored, .batch_done,
        .en(irq_en), .threshold(irq_count), .clr(irq_clr), .flag(irq_flag)
    );
endmodule

// File: rtl/cmdring_engine_chk.sv
module cmdring_engine_chk
    import cre_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_run,
    input logic [1:0]       cmd_size_sel,
    input logic [PTR_W-1:0] cmd_rp,
    input logic             mrd_req,
    input logic             rsp_dma_en,
    input logic [1:0]       rsp_size_sel,
    input logic [PTR_W-1:0] rsp_wp,
    input logic             rsp_ready,
    input logic             mwr_valid,
    input logic [AW-1:0]    mwr_addr,
    input logic             irq_en,
    input logic             irq_flag
);
    p_rp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_run && $past(cmd_run) && cmd_rp != $past(cmd_rp))
        |-> cmd_rp == (($past(cmd_rp) + ptr_t'(1)) & size_mask($past(cmd_size_sel))));

    p_rp_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_run |=> cmd_rp == '0);

    p_req_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req |-> cmd_run);

    p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (rsp_dma_en && rsp_size_sel != SZ_BAD));

    p_dma_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_dma_en |=> (rsp_wp == '0 && !mwr_valid));

    p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_dma_en && mwr_valid && !mwr_addr[2])
        |=> (!rsp_dma_en || (mwr_valid && mwr_addr[2])));

    p_wp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_dma_en && $past(rsp_dma_en) && rsp_wp != $past(rsp_wp))
        |-> rsp_wp == (($past(rsp_wp) + ptr_t'(1)) & size_mask($past(rsp_size_sel))));

    p_irq_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(irq_en));
endmodule

bind cmdring_engine cmdring_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_run(cmd_run), .cmd_size_sel(cmd_size_sel),
    .cmd_rp(cmd_rp), .mrd_req(mrd_req), .rsp_dma_en(rsp_dma_en),
    .rsp_size_sel(rsp_size_sel), .rsp_wp(rsp_wp), .rsp_ready(rsp_ready),
    .mwr_valid(mwr_valid), .mwr_addr(mwr_addr), .irq_en(irq_en), .irq_flag(irq_flag)
);

// File: tb/cmdring_engine_bench.sv
module cmdring_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cmd_base = 32'h1000;
    logic [1:0]  cmd_size_sel = 2'd1;
    logic [7:0]  cmd_wp = '0;
    logic        cmd_run = 1'b0;
    logic [7:0]  cmd_rp;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_valid = 1'b0;
    logic [31:0] mrd_data = '0;
    logic [15:0] codec_present = 16'hFFF7;
    logic        cdc_cmd_valid;
    logic [3:0]  cdc_cmd_addr;
    logic [31:0] cdc_cmd_word;
    logic [31:0] rsp_base = 32'h8000;
    logic [1:0]  rsp_size_sel = 2'd1;
    logic        rsp_dma_en = 1'b0;
    logic [7:0]  rsp_wp;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_data = '0;
    logic [3:0]  rsp_codec = '0;
    logic        rsp_unsol = 1'b0;
    logic        mwr_valid;
    logic [31:0] mwr_addr;
    logic [31:0] mwr_data;
    logic        irq_en = 1'b0;
    logic [7:0]  irq_count = '0;
    logic        irq_clr = 1'b0;
    logic        irq_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [35:0] exp_cmd[$];
    logic [63:0] exp_wr[$];

    always #5 clk = ~clk;

    cmdring_engine u_cmdring_engine (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[5:2], 12'h000, a[15:0]};
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mrd_valid <= mrd_req;
        mrd_data  <= mem_word(mrd_addr);
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare outputs against the scoreboard
    always @(negedge clk) begin
        if (rst_n && cdc_cmd_valid) begin
            if (exp_cmd.size() == 0) chk({28'h0, cdc_cmd_addr, cdc_cmd_word}, 64'hDEAD, "R5 unexpected command");
            else chk({28'h0, cdc_cmd_addr, cdc_cmd_word}, {28'h0, exp_cmd.pop_front()}, "R4 R5 command");
        end
        if (rst_n && mwr_valid) begin
            if (exp_wr.size() == 0) chk({mwr_addr, mwr_data}, 64'hDEAD, "R6 unexpected write");
            else chk({mwr_addr, mwr_data}, exp_wr.pop_front(), "R6 write");
        end
    end

    task automatic push_cmd(input int idx);
        logic [31:0] a = cmd_base + 32'(idx) * 4;
        logic [31:0] w = mem_word(a);
        if (codec_present[w[31:28]]) exp_cmd.push_back({w[31:28], w});
    endtask

    task automatic send_rsp(input logic [31:0] dat, input logic [3:0] cod, input logic uns,
                            input logic [7:0] exp_wp);
        logic [31:0] a = rsp_base + 32'(exp_wp) * 8;
        exp_wr.push_back({a, dat});
        exp_wr.push_back({a + 32'd4, 27'h0, uns, cod});
        @(negedge clk);
        while (!rsp_ready) @(negedge clk);
        rsp_valid = 1'b1; rsp_data = dat; rsp_codec = cod; rsp_unsol = uns;
        @(negedge clk);
        rsp_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R11 reset state
        chk(64'(cmd_rp), 64'h0, "R11 cmd_rp");
        chk(64'(rsp_wp), 64'h0, "R11 rsp_wp");
        chk(64'(irq_flag), 64'h0, "R11 irq_flag");
        chk(64'(rsp_ready), 64'h0, "R10 ready while disabled");

        // R2: invalid size refuses start
        cmd_size_sel = 2'd3; cmd_wp = 8'd2; cmd_run = 1'b1;
        idle(20);
        chk(64'(cmd_rp), 64'h0, "R2 no start with code 3");
        // R3: run already high, size becomes valid -> no start
        cmd_size_sel = 2'd1;
        idle(20);
        chk(64'(cmd_rp), 64'h0, "R3 no start without rising run");
        cmd_run = 1'b0; idle(2);

        // R1 R4 R5: 16-entry ring, codec 3 absent
        cmd_wp = 8'd4;
        for (int i = 1; i <= 4; i++) push_cmd(i);
        cmd_run = 1'b1; idle(40);
        chk(64'(cmd_rp), 64'h4, "R4 rp after batch");
        chk(64'(exp_cmd.size()), 64'h0, "R5 commands drained");
        // R3 clear
        cmd_run = 1'b0; idle(3);
        chk(64'(cmd_rp), 64'h0, "R3 rp cleared");

        // R1 2-entry wrap
        cmd_size_sel = 2'd0; cmd_wp = 8'd1; push_cmd(1);
        cmd_run = 1'b1; idle(20);
        chk(64'(cmd_rp), 64'h1, "R1 rp size 2");
        cmd_wp = 8'd0; push_cmd(0); idle(20);
        chk(64'(cmd_rp), 64'h0, "R1 rp wrap size 2");
        chk(64'(exp_cmd.size()), 64'h0, "R1 wrap fetch done");
        cmd_run = 1'b0; idle(3);

        // R1 256-entry wrap
        cmd_base = 32'h2000; cmd_size_sel = 2'd2; cmd_wp = 8'd255;
        for (int i = 1; i <= 255; i++) push_cmd(i);
        cmd_run = 1'b1; idle(1100);
        chk(64'(cmd_rp), 64'hFF, "R1 rp size 256");
        cmd_wp = 8'd0; push_cmd(0); idle(20);
        chk(64'(cmd_rp), 64'h0, "R1 rp wrap size 256");
        chk(64'(exp_cmd.size()), 64'h0, "R4 all fetched");
        cmd_run = 1'b0; idle(3);

        // R6 R7 responses on 16-entry ring, threshold 2
        rsp_dma_en = 1'b1; irq_en = 1'b1; irq_count = 8'd2;
        send_rsp(32'hA5A5_0001, 4'd5, 1'b0, 8'd1);
        chk(64'(rsp_wp), 64'h1, "R6 wp after first");
        chk(64'(irq_flag), 64'h0, "R7 below threshold");
        send_rsp(32'h5A5A_0002, 4'd2, 1'b1, 8'd2);
        chk(64'(rsp_wp), 64'h2, "R6 wp after second");
        chk(64'(irq_flag), 64'h1, "R7 threshold reached");
        irq_clr = 1'b1; idle(1); irq_clr = 1'b0; idle(1);
        chk(64'(irq_flag), 64'h0, "R9 flag cleared");

        // R8 batch end with pending count
        irq_count = 8'd5;
        send_rsp(32'h0000_0003, 4'd1, 1'b0, 8'd3);
        chk(64'(irq_flag), 64'h0, "R8 flag before batch");
        cmd_base = 32'h1000; cmd_size_sel = 2'd1; cmd_wp = 8'd1; push_cmd(1);
        cmd_run = 1'b1; idle(20);
        chk(64'(irq_flag), 64'h1, "R8 flag at batch end");
        irq_clr = 1'b1; idle(1); irq_clr = 1'b0;
        cmd_run = 1'b0; idle(3);

        // R9 disabled interrupts
        irq_en = 1'b0; irq_count = 8'd1;
        send_rsp(32'h0000_0004, 4'd0, 1'b0, 8'd4);
        chk(64'(irq_flag), 64'h0, "R9 no flag when disabled");

        // R10 disable resets wp; R2 invalid response size
        rsp_dma_en = 1'b0; idle(2);
        chk(64'(rsp_wp), 64'h0, "R10 wp reset");
        chk(64'(rsp_ready), 64'h0, "R10 not ready when disabled");
        rsp_size_sel = 2'd3; rsp_dma_en = 1'b1; idle(2);
        chk(64'(rsp_ready), 64'h0, "R2 not ready with code 3");
        rsp_size_sel = 2'd0; idle(1);
        chk(64'(rsp_ready), 64'h1, "R10 ready when enabled");
        send_rsp(32'h0000_0005, 4'd7, 1'b1, 8'd1);
        chk(64'(rsp_wp), 64'h1, "R6 wp size 2");
        send_rsp(32'h0000_0006, 4'd8, 1'b0, 8'd0);
        chk(64'(rsp_wp), 64'h0, "R1 wp wrap size 2");
        chk(64'(exp_wr.size()), 64'h0, "R6 writes drained");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule